// File: doc/BRIEF.md
# Classifier Action Forwarding Resolver

This block sits after a classification lookup in a switch ingress pipeline. The address-table lookup has already produced a destination port map, a traffic class and a drop-precedence color for the packet. When a classification rule hits, the block applies that rule's three-word action record to those values. The rule can keep, prune, replace or extend the forwarding map. It can also override the traffic class and the color, and it supplies an 8-bit classification ID that the egress tag carries.

The rule's destination field has one bit fewer than there are physical ports, because one physical port number (port 6 by default) has no bit in it. The block widens that field into a physical port map before it merges the two. On a miss, all lookup values pass through unchanged. Each result is registered and appears one clock after its input, with a valid strobe beside it.

Top module: `cfr_resolver`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. The data outputs load only on such an input cycle and hold their value otherwise.
- R2: On a miss (`in_valid` high, `in_hit` low), the lookup port map, class and color appear unchanged one cycle later, and `out_class_id` is 0. Both action words are ignored.
- R3: The forwarding mode is action word 0 bits [25:24]. Mode 0 leaves the lookup port map unchanged.
- R4: Mode 1 removes from the lookup map every port listed in the rule map.
- R5: Mode 2 replaces the lookup map with the rule map.
- R6: Mode 3 adds every port listed in the rule map to the lookup map.
- R7: The rule map is action word 0 bits [22:14]. Rule bit i selects physical port i when i < 6 and physical port i+1 otherwise. Physical port 6 is therefore never set by a rule, and a prune can never clear it.
- R8: When action word 0 bit 13 is set on a hit, the output class is word 0 bits [12:10]. Otherwise it is the lookup class.
- R9: On a hit, `out_class_id` equals action word 1 bits [27:20].
- R10: When action word 1 bit 28 is set on a hit, bits [30:29] give the new color: 0 green, 1 yellow, 2 red. The code 3 leaves the color unchanged, as does a clear bit 28.
- R11: Action word 2 and all other bits of words 0 and 1 have no effect on any output.
- R12: A synchronous active-low reset clears `out_valid` and every data output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input record present this cycle |
| in_hit | input | 1 | A classification rule matched |
| in_lkp_map | input | 10 | Lookup-derived destination map, one bit per physical port |
| in_tc | input | 3 | Lookup traffic class |
| in_color | input | 2 | Incoming color (0 green, 1 yellow, 2 red) |
| in_act_w0 | input | 32 | Action word 0: rule map, forwarding mode, class override |
| in_act_w1 | input | 32 | Action word 1: chain ID, color override |
| in_act_w2 | input | 32 | Action word 2, unused by this block |
| out_valid | output | 1 | Result present |
| out_dst_map | output | 10 | Resolved destination map, physical ports |
| out_tc | output | 3 | Resolved traffic class |
| out_color | output | 2 | Resolved color |
| out_class_id | output | 8 | Classification ID for the egress tag |

## Verification
Every output is one register stage away from its inputs, so a wrong mode decode, a bit-index slip in the port widening, or a lost override appears on the very next result. A one-position shift in the widening moves a port across the gap at port 6. That shows up as a set port-6 bit after a replace, or as a neighbour port that is wrongly kept after a prune. The bench therefore targets rule maps that straddle the gap in all four modes. A wrongly gated hit shows as a nonzero class ID or a rewritten map on a miss. A stale enable on the register shows as outputs that change while `out_valid` is low.

// File: rtl/cfr_pkg.sv
// Package: cfr_pkg
// Shared field positions and enumerations for the classifier action resolver.
// Assumes the action record layout is fixed; only port counts are parameters.
package cfr_pkg;

    // Action word 0 field positions
    localparam int W0_TC_LO   = 10;
    localparam int W0_TC_EN   = 13;
    localparam int W0_MAP_LO  = 14;
    localparam int W0_MODE_LO = 24;

    // Action word 1 field positions
    localparam int W1_CID_LO  = 20;
    localparam int W1_COL_EN  = 28;
    localparam int W1_COL_LO  = 29;

    localparam int TC_W  = 3;
    localparam int CID_W = 8;
    localparam int COL_W = 2;

    typedef enum logic [1:0] {
        FWD_KEEP    = 2'd0,
        FWD_PRUNE   = 2'd1,
        FWD_REPLACE = 2'd2,
        FWD_ADD     = 2'd3
    } fwd_mode_e;

    typedef enum logic [1:0] {
        COL_GREEN  = 2'd0,
        COL_YELLOW = 2'd1,
        COL_RED    = 2'd2,
        COL_RSVD   = 2'd3
    } color_e;

endpackage

// File: rtl/cfr_port_remap.sv
// Module: cfr_port_remap
// Widens the rule destination field into a physical port map. The field has
// no bit for GAP_PORT: bits below the gap map 1:1, bits at or above it map
// to the next higher physical port. Assumes 0 < GAP_PORT < PHYS_PORTS.
module cfr_port_remap #(
    parameter int PHYS_PORTS = 10,
    parameter int GAP_PORT   = 6,
    localparam int RULE_W    = PHYS_PORTS - 1
) (
    input  logic [RULE_W-1:0]     rule_map,
    output logic [PHYS_PORTS-1:0] phys_map
);

    // One assignment per physical port, picked by position against the gap
    for (genvar p = 0; p < PHYS_PORTS; p++) begin : g_port
        if (p == GAP_PORT) begin : g_gap
            assign phys_map[p] = 1'b0;
        end else if (p < GAP_PORT) begin : g_low
            assign phys_map[p] = rule_map[p];
        end else begin : g_high
            assign phys_map[p] = rule_map[p-1];
        end
    end

endmodule

// File: rtl/cfr_map_merge.sv
// Module: cfr_map_merge
// Combines the lookup port map with the widened rule map under the 2-bit
// forwarding mode. Purely combinational; both maps are physical port maps.
module cfr_map_merge
    import cfr_pkg::*;
#(
    parameter int PHYS_PORTS = 10
) (
    input  fwd_mode_e             mode,
    input  logic [PHYS_PORTS-1:0] lkp_map,
    input  logic [PHYS_PORTS-1:0] rule_map,
    output logic [PHYS_PORTS-1:0] merged_map
);

    // Select the merge operation named by the mode
    always_comb begin
        unique case (mode)
            FWD_KEEP:    merged_map = lkp_map;
            FWD_PRUNE:   merged_map = lkp_map & ~rule_map;
            FWD_REPLACE: merged_map = rule_map;
            FWD_ADD:     merged_map = lkp_map | rule_map;
            default:     merged_map = lkp_map;
        endcase
    end

endmodule

// File: rtl/cfr_qos_rewrite.sv
// Module: cfr_qos_rewrite
// Applies the optional traffic class and color overrides. The reserved color
// code leaves the color as it came in. Assumes overrides are pre-gated by hit.
module cfr_qos_rewrite
    import cfr_pkg::*;
(
    input  logic [TC_W-1:0]  tc_in,
    input  logic             tc_chg,
    input  logic [TC_W-1:0]  tc_new,
    input  logic [COL_W-1:0] col_in,
    input  logic             col_chg,
    input  color_e           col_new,
    output logic [TC_W-1:0]  tc_out,
    output logic [COL_W-1:0] col_out
);

    // Class override when enabled
    always_comb begin
        tc_out = tc_chg ? tc_new : tc_in;
    end

    // Color override for defined codes only
    always_comb begin
        col_out = col_in;
        if (col_chg && (col_new != COL_RSVD)) begin
            col_out = col_new;
        end
    end

endmodule

// File: rtl/cfr_resolver.sv
// Module: cfr_resolver (top)
// Resolves a packet's final destination map, class, color and classification
// ID from the lookup result and a matched rule's action record. One register
// stage; results and out_valid appear one clock after in_valid. Assumes the
// rule destination field (word 0 from bit 14) holds PHYS_PORTS-1 bits.
module cfr_resolver
    import cfr_pkg::*;
#(
    parameter int PHYS_PORTS = 10,
    parameter int GAP_PORT   = 6,
    localparam int RULE_W    = PHYS_PORTS - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_hit,
    input  logic [PHYS_PORTS-1:0] in_lkp_map,
    input  logic [TC_W-1:0]       in_tc,
    input  logic [COL_W-1:0]      in_color,
    input  logic [31:0]           in_act_w0,
    input  logic [31:0]           in_act_w1,
    input  logic [31:0]           in_act_w2,
    output logic                  out_valid,
    output logic [PHYS_PORTS-1:0] out_dst_map,
    output logic [TC_W-1:0]       out_tc,
    output logic [COL_W-1:0]      out_color,
    output logic [CID_W-1:0]      out_class_id
);

    // Field extraction
    logic [RULE_W-1:0]     rule_field;
    logic [PHYS_PORTS-1:0] rule_phys;
    fwd_mode_e             mode_eff;
    logic [PHYS_PORTS-1:0] map_nxt;
    logic [TC_W-1:0]       tc_nxt;
    logic [COL_W-1:0]      col_nxt;
    logic [CID_W-1:0]      cid_nxt;

    assign rule_field = in_act_w0[W0_MAP_LO +: RULE_W];

    // A miss forces the keep mode so the lookup map passes through
    always_comb begin
        mode_eff = in_hit ? fwd_mode_e'(in_act_w0[W0_MODE_LO +: 2]) : FWD_KEEP;
    end

    // Classification ID is only meaningful on a hit
    always_comb begin
        cid_nxt = in_hit ? in_act_w1[W1_CID_LO +: CID_W] : '0;
    end

    cfr_port_remap #(
        .PHYS_PORTS (PHYS_PORTS),
        .GAP_PORT   (GAP_PORT)
    ) u_remap (
        .rule_map (rule_field),
        .phys_map (rule_phys)
    );

    cfr_map_merge #(
        .PHYS_PORTS (PHYS_PORTS)
    ) u_merge (
        .mode       (mode_eff),
        .lkp_map    (in_lkp_map),
        .rule_map   (rule_phys),
        .merged_map (map_nxt)
    );

    cfr_qos_rewrite u_qos (
        .tc_in   (in_tc),
        .tc_chg  (in_hit && in_act_w0[W0_TC_EN]),
        .tc_new  (in_act_w0[W0_TC_LO +: TC_W]),
        .col_in  (in_color),
        .col_chg (in_hit && in_act_w1[W1_COL_EN]),
        .col_new (color_e'(in_act_w1[W1_COL_LO +: COL_W])),
        .tc_out  (tc_nxt),
        .col_out (col_nxt)
    );

    // Bits of the record that this block deliberately does not consume
    logic unused_bits;
    assign unused_bits = ^{in_act_w2, in_act_w0[W0_TC_LO-1:0],
                           in_act_w0[31:W0_MODE_LO+2],
                           in_act_w0[W0_MODE_LO-1:W0_MAP_LO+RULE_W],
                           in_act_w1[W1_CID_LO-1:0], in_act_w1[31]};

    // Valid strobe register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded only on an input cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dst_map  <= '0;
            out_tc       <= '0;
            out_color    <= '0;
            out_class_id <= '0;
        end else if (in_valid) begin
            out_dst_map  <= map_nxt;
            out_tc       <= tc_nxt;
            out_color    <= col_nxt;
            out_class_id <= cid_nxt;
        end
    end

    // Assertions
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_dst_map) && $stable(out_class_id)));
    a_r2_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_hit) |=> (out_dst_map == $past(in_lkp_map)
                                   && out_tc == $past(in_tc)
                                   && out_color == $past(in_color)
                                   && out_class_id == '0));
    a_r4_prune_no_new_port: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hit && in_act_w0[W0_MODE_LO +: 2] == 2'd1)
        |=> ((out_dst_map & ~$past(in_lkp_map)) == '0));
    a_r6_add_keeps_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hit && in_act_w0[W0_MODE_LO +: 2] == 2'd3)
        |=> ((out_dst_map & $past(in_lkp_map)) == $past(in_lkp_map)));
    a_r7_replace_skips_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hit && in_act_w0[W0_MODE_LO +: 2] == 2'd2)
        |=> !out_dst_map[GAP_PORT]);
    a_r9_hit_class_id: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_hit) |=> (out_class_id == $past(in_act_w1[W1_CID_LO +: CID_W])));

endmodule

// File: tb/tb_cfr_resolver.sv
`timescale 1ns/1ps
module tb_cfr_resolver;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_hit;
    logic [9:0]  in_lkp_map;
    logic [2:0]  in_tc;
    logic [1:0]  in_color;
    logic [31:0] in_act_w0, in_act_w1, in_act_w2;
    logic        out_valid;
    logic [9:0]  out_dst_map;
    logic [2:0]  out_tc;
    logic [1:0]  out_color;
    logic [7:0]  out_class_id;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    bit model_on = 0;

    always #2 clk = ~clk;   // 250 MHz

    cfr_resolver dut (
        .clk, .rst_n, .in_valid, .in_hit, .in_lkp_map, .in_tc, .in_color,
        .in_act_w0, .in_act_w1, .in_act_w2,
        .out_valid, .out_dst_map, .out_tc, .out_color, .out_class_id
    );

    // Behavioural reference
    function automatic logic [9:0] ref_map(input logic hit, input logic [9:0] lkp,
                                           input logic [31:0] w0);
        logic [9:0] rule = '0;
        int sel;
        for (int p = 0; p < 10; p++) begin
            if (p < 6)      rule[p] = w0[14 + p];
            else if (p > 6) rule[p] = w0[13 + p];
        end
        if (!hit) return lkp;
        sel = int'(w0[25:24]);
        if (sel == 1) return lkp & ~rule;
        if (sel == 2) return rule;
        if (sel == 3) return lkp | rule;
        return lkp;
    endfunction

    logic       e_valid = 0;
    logic [9:0] e_map = 0;
    logic [2:0] e_tc = 0;
    logic [1:0] e_col = 0;
    logic [7:0] e_cid = 0;

    // Model update on each clock
    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 0; e_map <= 0; e_tc <= 0; e_col <= 0; e_cid <= 0;
        end else begin
            e_valid <= in_valid;
            if (in_valid) begin
                e_map <= ref_map(in_hit, in_lkp_map, in_act_w0);
                e_tc  <= (in_hit && in_act_w0[13]) ? in_act_w0[12:10] : in_tc;
                e_col <= (in_hit && in_act_w1[28] && in_act_w1[30:29] != 2'd3)
                         ? in_act_w1[30:29] : in_color;
                e_cid <= in_hit ? in_act_w1[27:20] : 8'd0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (model_on && !done) begin
            check("R1",  "model valid", {31'b0, out_valid}, {31'b0, e_valid});
            check("R7",  "model map",   {22'b0, out_dst_map}, {22'b0, e_map});
            check("R8",  "model tc",    {29'b0, out_tc}, {29'b0, e_tc});
            check("R10", "model color", {30'b0, out_color}, {30'b0, e_col});
            check("R9",  "model cid",   {24'b0, out_class_id}, {24'b0, e_cid});
        end
    end

    function automatic logic [31:0] w0_of(input int mode, input logic [8:0] rmap,
                                          input bit tc_en, input int tc);
        return (32'(mode) << 24) | (32'(rmap) << 14) | (32'(tc_en) << 13) | (32'(tc) << 10);
    endfunction

    function automatic logic [31:0] w1_of(input int cid, input bit col_en, input int col);
        return (32'(cid) << 20) | (32'(col_en) << 28) | (32'(col) << 29);
    endfunction

    // Drive one record at a negedge, return at the next negedge with results visible
    task automatic send(input bit hit, input logic [9:0] lkp, input int tc, input int col,
                        input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
        in_valid = 1; in_hit = hit; in_lkp_map = lkp; in_tc = 3'(tc); in_color = 2'(col);
        in_act_w0 = w0; in_act_w1 = w1; in_act_w2 = w2;
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] ref10;
        rst_n = 0; in_valid = 0; in_hit = 0; in_lkp_map = 0; in_tc = 0; in_color = 0;
        in_act_w0 = 0; in_act_w1 = 0; in_act_w2 = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", "valid", {31'b0, out_valid}, 0);
        check("R12", "map", {22'b0, out_dst_map}, 0);
        check("R12", "cid", {24'b0, out_class_id}, 0);
        rst_n = 1;
        model_on = 1;
        @(negedge clk);

        // R2: miss passes through even with a replace action present
        send(0, 10'h3FF, 5, 1, w0_of(2, 9'h000, 1, 2), w1_of(8'hAB, 1, 2), 0);
        check("R2", "map", {22'b0, out_dst_map}, 32'h3FF);
        check("R2", "tc",  {29'b0, out_tc}, 5);
        check("R2", "color", {30'b0, out_color}, 1);
        check("R2", "cid", {24'b0, out_class_id}, 0);
        // R1: no valid after idle cycle, outputs held
        @(negedge clk);
        check("R1", "valid low", {31'b0, out_valid}, 0);
        check("R1", "map held", {22'b0, out_dst_map}, 32'h3FF);

        // R3: keep mode
        send(1, 10'h041, 0, 0, w0_of(0, 9'h1FF, 0, 0), w1_of(8'h11, 0, 0), 0);
        check("R3", "keep map", {22'b0, out_dst_map}, 32'h041);
        check("R1", "valid", {31'b0, out_valid}, 1);
        // R5 / R7: replace across the gap, bits 0,6,8 -> ports 0,7,9
        send(1, 10'h07E, 0, 0, w0_of(2, 9'h141, 0, 0), 0, 0);
        check("R5", "replace map", {22'b0, out_dst_map}, 32'h281);
        check("R7", "gap bit clear", {31'b0, out_dst_map[6]}, 0);
        // R4: prune all rule ports, port 6 survives
        send(1, 10'h3FF, 0, 0, w0_of(1, 9'h1FF, 0, 0), 0, 0);
        check("R4", "prune map", {22'b0, out_dst_map}, 32'h040);
        // R6: add rule bits 5,6 -> ports 5,7
        send(1, 10'h040, 0, 0, w0_of(3, 9'h060, 0, 0), 0, 0);
        check("R6", "add map", {22'b0, out_dst_map}, 32'h0E0);
        // R8: class override and no override
        send(1, 10'h001, 2, 0, w0_of(0, 0, 1, 6), 0, 0);
        check("R8", "tc override", {29'b0, out_tc}, 6);
        send(1, 10'h001, 2, 0, w0_of(0, 0, 0, 6), 0, 0);
        check("R8", "tc kept", {29'b0, out_tc}, 2);
        // R9: chain ID
        send(1, 10'h001, 0, 0, 0, w1_of(8'hA5, 0, 0), 0);
        check("R9", "cid", {24'b0, out_class_id}, 32'hA5);
        // R10: red, reserved code, disabled
        send(1, 10'h001, 0, 0, 0, w1_of(0, 1, 2), 0);
        check("R10", "red", {30'b0, out_color}, 2);
        send(1, 10'h001, 0, 1, 0, w1_of(0, 1, 3), 0);
        check("R10", "reserved keeps", {30'b0, out_color}, 1);
        send(1, 10'h001, 0, 1, 0, w1_of(0, 0, 2), 0);
        check("R10", "disabled keeps", {30'b0, out_color}, 1);
        // R11: junk in unused fields and word 2
        send(1, 10'h00F, 3, 2, w0_of(3, 9'h100, 0, 5) | 32'hFC8003FF,
             w1_of(8'h3C, 0, 1) | 32'h800FFFFF, 32'hDEADBEEF);
        check("R11", "map", {22'b0, out_dst_map}, 32'h20F);
        check("R11", "tc", {29'b0, out_tc}, 3);
        check("R11", "color", {30'b0, out_color}, 2);
        check("R11", "cid", {24'b0, out_class_id}, 32'h3C);

        // Random traffic checked by the model every clock
        for (int i = 0; i < 400; i++) begin
            in_valid = 1'($urandom_range(0, 3) != 0);
            in_hit = 1'($urandom);
            in_lkp_map = 10'($urandom);
            in_tc = 3'($urandom);
            in_color = 2'($urandom);
            in_act_w0 = $urandom; in_act_w1 = $urandom; in_act_w2 = $urandom;
            @(negedge clk);
        end
        in_valid = 0;
        ref10 = ref_map(1, 10'h000, w0_of(2, 9'h1FF, 0, 0));
        check("R7", "ref all rule bits", {22'b0, ref10}, 32'h3BF);
        // R12: reset mid-run
        rst_n = 0;
        @(negedge clk);
        check("R12", "reset valid", {31'b0, out_valid}, 0);
        check("R12", "reset map", {22'b0, out_dst_map}, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule